// File: doc/BRIEF.md
# Floating-Point Control Register with Accuracy Mode

This block holds the floating-point control and status state of a core: five sticky exception flags, a dynamic rounding mode and a three-bit result-accuracy mode. Software reaches it through a CSR port with three views: the whole register, the rounding mode alone, or the flags alone. The floating-point unit ORs its exception flags in as each instruction retires.

A combinational check port serves every floating-point instruction at decode. It takes the rounding field from the instruction and an operation class. It returns the rounding mode that takes effect, the accuracy mode that takes effect, and an illegal-instruction trap request. A trap is raised for an invalid rounding mode. A trap is also raised for an accuracy mode that the hardware cannot serve for that class, so that software can emulate the operation.

The accuracy mode is only a floor. A class that supports a more accurate mode than the one requested accepts the request. Operand and result formats are never affected. The hardware support table is a parameter.

Top module: `fp_ctrl_csr`

## Requirements
- R1: After reset, flags, rounding mode and accuracy mode are all zero, and every view reads zero.
- R2: In the full view (csr_view_i = 00), a write stores flags from bits 4:0, the rounding mode from bits 7:5 and the accuracy mode from bits 10:8. A read returns them at the same positions, and bits 31:11 always read zero.
- R3: The rounding view (01) writes and reads only the rounding mode, at bits 2:0. The flags view (10) writes and reads only the flags, at bits 4:0. View 11 reads zero and ignores writes. A write leaves every field outside its view unchanged.
- R4: When acc_valid_i is high, acc_flags_i is ORed into the flags in that cycle. Flags never clear except through a CSR write.
- R5: A CSR write to the full or flags view in the same cycle as an accrual wins, and the flags take the written value. A rounding-view write does not block the accrual.
- R6: An instruction rounding field of 111 selects the stored rounding mode. Any other field value passes through unchanged on chk_rm_o.
- R7: The trap is raised when the rounding mode that takes effect is 101, 110 or 111. This covers the stored mode selected by a field of 111, and a field of 101 or 110 used directly.
- R8: Accuracy codes are 000 (correctly rounded), 010 (error under 1 ULP), 100 (graphics-grade) and 110 (approximate). An odd code can be written and is reported on chk_acc_o, but it reads back as 000 and always raises the trap.
- R9: Classes are 00 add/mul, 01 div, 10 sqrt and 11 other. A pair traps only when neither the requested mode nor any more accurate mode (a lower code) is supported for that class. The default table supports modes {000,010} for add/mul, {000,100} for div, {100} for sqrt and {000,110} for other.
- R10: chk_acc_o reports the stored accuracy code. After reset, an add/mul with dynamic rounding gives rounding 000 and accuracy 000 and does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_view_i | input | 2 | CSR view: 00 full, 01 rounding, 10 flags, 11 none |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for the selected view |
| acc_valid_i | input | 1 | Instruction retires with flags to accrue |
| acc_flags_i | input | 5 | Exception flags from the FPU |
| chk_rm_i | input | 3 | Rounding field of the instruction |
| chk_class_i | input | 2 | Operation class of the instruction |
| chk_rm_o | output | 3 | Rounding mode that takes effect |
| chk_acc_o | output | 3 | Accuracy mode that takes effect |
| chk_trap_o | output | 1 | Illegal-instruction trap request |

## Verification
The assertions assume that the write strobe, the view select and the accrual inputs are stable around each rising edge and that the inputs are known after reset. The bench drives all inputs on the falling edge and holds them for a full cycle. The check port is combinational, so the properties on it assume the instruction inputs stay constant across the sampling edge. The bench changes them only at falling edges and reads the outputs after a short settle delay.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int XLEN   = 32;
  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int ACC_W  = 3;
  localparam int N_MODE = 1 << (ACC_W - 1);

  typedef enum logic [1:0] {
    VIEW_FULL  = 2'b00,
    VIEW_RM    = 2'b01,
    VIEW_FLAGS = 2'b10,
    VIEW_NONE  = 2'b11
  } csr_view_e;

  localparam logic [RM_W-1:0] RM_DYN = 3'b111;
endpackage

// File: rtl/fpcsr_state.sv
module fpcsr_state
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        view_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic              acc_valid_i,
  input  logic [FLAG_W-1:0] acc_flags_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [RM_W-1:0]   rm_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rm_q;
  logic [ACC_W-1:0]  acc_q;
  logic wr_full, wr_rm, wr_flags;

  assign wr_full  = we_i && (view_i == VIEW_FULL);
  assign wr_rm    = we_i && (view_i == VIEW_RM);
  assign wr_flags = we_i && (view_i == VIEW_FLAGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      rm_q    <= '0;
      acc_q   <= '0;
    end else begin
      // CSR write to the flags beats accrual
      if (wr_full || wr_flags)  flags_q <= wdata_i[FLAG_W-1:0];
      else if (acc_valid_i)     flags_q <= flags_q | acc_flags_i;
      if (wr_full)              rm_q <= wdata_i[FLAG_W +: RM_W];
      else if (wr_rm)           rm_q <= wdata_i[RM_W-1:0];
      if (wr_full)              acc_q <= wdata_i[FLAG_W+RM_W +: ACC_W];
    end
  end

  assign flags_o = flags_q;
  assign rm_o    = rm_q;
  assign acc_o   = acc_q;

  p_sticky_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_full || wr_flags) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  p_write_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_full || wr_flags) |=> (flags_q == $past(wdata_i[FLAG_W-1:0])));
  p_rm_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_full || wr_rm) |=> $stable(rm_q));
  p_acc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_full |=> $stable(acc_q));
endmodule

// File: rtl/fpcsr_acc_cover.sv
module fpcsr_acc_cover
  import fpcsr_pkg::*;
#(
  parameter int N_CLASS = 4,
  parameter logic [N_CLASS*N_MODE-1:0] ACC_SUPPORT = 16'h9453,
  localparam int CLS_W = $clog2(N_CLASS)
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             ok_o
);
  // cov[c][m]: class c can serve mode m with mode m or a more accurate one
  logic [N_CLASS-1:0][N_MODE-1:0] cov;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
    logic [N_MODE-1:0] cov_c;
    always_comb begin
      cov_c = '0;
      for (int k = 0; k < N_MODE; k++) begin
        if (ACC_SUPPORT[c*N_MODE+k]) begin
          for (int m = k; m < N_MODE; m++) cov_c[m] = 1'b1;
        end
      end
    end
    assign cov[c] = cov_c;
  end

  // odd codes are unlisted and never served
  assign ok_o = !acc_i[0] && cov[cls_i][acc_i[ACC_W-1:1]];
endmodule

// File: rtl/fpcsr_check.sv
module fpcsr_check
  import fpcsr_pkg::*;
#(
  parameter int N_CLASS = 4,
  parameter logic [N_CLASS*N_MODE-1:0] ACC_SUPPORT = 16'h9453,
  localparam int CLS_W = $clog2(N_CLASS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RM_W-1:0]  dyn_rm_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [RM_W-1:0]  inst_rm_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic [RM_W-1:0]  rm_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             trap_o
);
  logic acc_ok, rm_bad;

  fpcsr_acc_cover #(.N_CLASS(N_CLASS), .ACC_SUPPORT(ACC_SUPPORT)) u_cover (
    .acc_i (acc_i),
    .cls_i (cls_i),
    .ok_o  (acc_ok)
  );

  assign rm_o   = (inst_rm_i == RM_DYN) ? dyn_rm_i : inst_rm_i;
  assign rm_bad = (rm_o > 3'b100);
  assign acc_o  = acc_i;
  assign trap_o = rm_bad || !acc_ok;

  p_odd_acc_trap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i[0] |-> trap_o);
  p_bad_rm_trap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((inst_rm_i == RM_DYN) && (dyn_rm_i > 3'b100)) |-> trap_o);
  p_default_ok_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_i == 3'b000) && (inst_rm_i == 3'b000) && (cls_i == '0)
     && ACC_SUPPORT[0]) |-> !trap_o);
endmodule

// File: rtl/fp_ctrl_csr.sv
module fp_ctrl_csr
  import fpcsr_pkg::*;
#(
  parameter int N_CLASS = 4,
  parameter logic [N_CLASS*N_MODE-1:0] ACC_SUPPORT = 16'h9453,
  localparam int CLS_W = $clog2(N_CLASS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_view_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  input  logic              acc_valid_i,
  input  logic [FLAG_W-1:0] acc_flags_i,
  input  logic [RM_W-1:0]   chk_rm_i,
  input  logic [CLS_W-1:0]  chk_class_i,
  output logic [RM_W-1:0]   chk_rm_o,
  output logic [ACC_W-1:0]  chk_acc_o,
  output logic              chk_trap_o
);
  logic [FLAG_W-1:0] flags;
  logic [RM_W-1:0]   rm;
  logic [ACC_W-1:0]  acc, acc_rd;

  fpcsr_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (csr_we_i),
    .view_i      (csr_view_i),
    .wdata_i     (csr_wdata_i),
    .acc_valid_i (acc_valid_i),
    .acc_flags_i (acc_flags_i),
    .flags_o     (flags),
    .rm_o        (rm),
    .acc_o       (acc)
  );

  fpcsr_check #(.N_CLASS(N_CLASS), .ACC_SUPPORT(ACC_SUPPORT)) u_check (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dyn_rm_i  (rm),
    .acc_i     (acc),
    .inst_rm_i (chk_rm_i),
    .cls_i     (chk_class_i),
    .rm_o      (chk_rm_o),
    .acc_o     (chk_acc_o),
    .trap_o    (chk_trap_o)
  );

  assign acc_rd = acc[0] ? '0 : acc;

  always_comb begin
    csr_rdata_o = '0;
    unique case (csr_view_i)
      VIEW_FULL:  csr_rdata_o[FLAG_W+RM_W+ACC_W-1:0] = {acc_rd, rm, flags};
      VIEW_RM:    csr_rdata_o[RM_W-1:0] = rm;
      VIEW_FLAGS: csr_rdata_o[FLAG_W-1:0] = flags;
      default:    csr_rdata_o = '0;
    endcase
  end

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rdata_o[XLEN-1:FLAG_W+RM_W+ACC_W] == '0);
  p_dyn_select_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_rm_i == RM_DYN) |-> (chk_rm_o == csr_rdata_o[FLAG_W +: RM_W]
                              || csr_view_i != VIEW_FULL));
  p_acc_report_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_acc_o[0] && (csr_view_i == VIEW_FULL)
      |-> (chk_acc_o == csr_rdata_o[FLAG_W+RM_W +: ACC_W]));
endmodule

// File: tb/tb_fp_ctrl_csr.sv
module tb_fp_ctrl_csr;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [1:0]  csr_view_i = 2'b00;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic [4:0]  acc_flags_i = '0;
  logic [2:0]  chk_rm_i = '0;
  logic [1:0]  chk_class_i = '0;
  logic [2:0]  chk_rm_o;
  logic [2:0]  chk_acc_o;
  logic        chk_trap_o;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fp_ctrl_csr dut (.clk_i(clk), .rst_ni(rst_ni), .csr_we_i(csr_we_i),
    .csr_view_i(csr_view_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .acc_valid_i(acc_valid_i), .acc_flags_i(acc_flags_i), .chk_rm_i(chk_rm_i),
    .chk_class_i(chk_class_i), .chk_rm_o(chk_rm_o), .chk_acc_o(chk_acc_o),
    .chk_trap_o(chk_trap_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] v, input logic [31:0] d,
                           input logic av = 1'b0, input logic [4:0] af = '0);
    @(negedge clk);
    csr_we_i = 1'b1; csr_view_i = v; csr_wdata_i = d;
    acc_valid_i = av; acc_flags_i = af;
    @(negedge clk);
    csr_we_i = 1'b0; acc_valid_i = 1'b0; acc_flags_i = '0; csr_view_i = 2'b00;
  endtask

  task automatic accrue(input logic [4:0] f);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_flags_i = f;
    @(negedge clk);
    acc_valid_i = 1'b0; acc_flags_i = '0;
  endtask

  task automatic csr_read(input logic [1:0] v, output logic [31:0] d);
    csr_view_i = v; #1; d = csr_rdata_o; csr_view_i = 2'b00;
  endtask

  task automatic probe(input logic [2:0] rm, input logic [1:0] cls);
    chk_rm_i = rm; chk_class_i = cls; #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int v = 0; v < 4; v++) begin
      csr_read(v[1:0], d);
      check("R1 reset read", d, 32'h0);
    end
    probe(3'b111, 2'b00);
    check("R10 reset add dyn rm", {29'b0, chk_rm_o}, 32'h0);
    check("R10 reset acc", {29'b0, chk_acc_o}, 32'h0);
    check("R10 reset no trap", {31'b0, chk_trap_o}, 32'h0);
  endtask

  task automatic t_full_view;
    logic [31:0] d;
    csr_write(2'b00, 32'hFFFF_F000 | {21'b0, 3'b100, 3'b011, 5'b10101});
    csr_read(2'b00, d);
    check("R2 full layout, reserved zero", d, {21'b0, 3'b100, 3'b011, 5'b10101});
  endtask

  task automatic t_sub_views;
    logic [31:0] d;
    csr_write(2'b01, 32'hFFFF_FFF2);
    csr_read(2'b01, d);
    check("R3 rm view", d, 32'h2);
    csr_write(2'b10, 32'hFFFF_FFE6);
    csr_read(2'b10, d);
    check("R3 flags view", d, 32'h06);
    csr_read(2'b00, d);
    check("R3 other fields kept", d, {21'b0, 3'b100, 3'b010, 5'b00110});
    csr_write(2'b11, 32'hFFFF_FFFF);
    csr_read(2'b11, d);
    check("R3 view 11 reads zero", d, 32'h0);
    csr_read(2'b00, d);
    check("R3 view 11 write ignored", d, {21'b0, 3'b100, 3'b010, 5'b00110});
  endtask

  task automatic t_accrue;
    logic [31:0] d;
    csr_write(2'b10, 32'h0);
    accrue(5'b00001);
    accrue(5'b01000);
    csr_read(2'b10, d);
    check("R4 accrual OR", d, 32'h09);
    accrue(5'b00000);
    csr_read(2'b10, d);
    check("R4 sticky", d, 32'h09);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    csr_write(2'b10, 32'h01, 1'b1, 5'b10000);
    csr_read(2'b10, d);
    check("R5 flags write wins", d, 32'h01);
    csr_write(2'b00, {21'b0, 3'b000, 3'b000, 5'b00010}, 1'b1, 5'b00100);
    csr_read(2'b10, d);
    check("R5 full write wins", d, 32'h02);
    csr_write(2'b01, 32'h1, 1'b1, 5'b01000);
    csr_read(2'b10, d);
    check("R5 rm write keeps accrual", d, 32'h0A);
  endtask

  task automatic t_rm_resolve;
    csr_write(2'b01, 32'h3);
    probe(3'b111, 2'b00);
    check("R6 dyn selects stored", {29'b0, chk_rm_o}, 32'h3);
    check("R6 dyn valid no trap", {31'b0, chk_trap_o}, 32'h0);
    probe(3'b001, 2'b00);
    check("R6 static passes", {29'b0, chk_rm_o}, 32'h1);
    probe(3'b100, 2'b00);
    check("R6 static 100 ok", {31'b0, chk_trap_o}, 32'h0);
  endtask

  task automatic t_rm_invalid;
    for (int r = 5; r < 8; r++) begin
      csr_write(2'b01, r);
      probe(3'b111, 2'b00);
      check("R7 dyn invalid trap", {31'b0, chk_trap_o}, 32'h1);
      probe(3'b000, 2'b00);
      check("R7 static ignores bad dyn", {31'b0, chk_trap_o}, 32'h0);
    end
    probe(3'b101, 2'b00);
    check("R7 static 101 trap", {31'b0, chk_trap_o}, 32'h1);
    probe(3'b110, 2'b00);
    check("R7 static 110 trap", {31'b0, chk_trap_o}, 32'h1);
  endtask

  task automatic t_acc_odd;
    logic [31:0] d;
    for (int a = 1; a < 8; a += 2) begin
      csr_write(2'b00, {21'b0, a[2:0], 3'b000, 5'b0});
      csr_read(2'b00, d);
      check("R8 odd acc reads zero", d, 32'h0);
      probe(3'b000, 2'b00);
      check("R8 odd acc trap", {31'b0, chk_trap_o}, 32'h1);
      check("R8 odd acc reported", {29'b0, chk_acc_o}, {29'b0, a[2:0]});
    end
  endtask

  task automatic t_support;
    // expected trap per [class][mode] for the default table
    logic [3:0] exp_trap [4];
    exp_trap[0] = 4'b0000; exp_trap[1] = 4'b0000;
    exp_trap[2] = 4'b0011; exp_trap[3] = 4'b0000;
    for (int m = 0; m < 4; m++) begin
      csr_write(2'b00, {21'b0, m[1:0], 1'b0, 3'b000, 5'b0});
      for (int c = 0; c < 4; c++) begin
        probe(3'b000, c[1:0]);
        check("R9 support matrix", {31'b0, chk_trap_o}, {31'b0, exp_trap[c][m]});
        check("R10 acc reported", {29'b0, chk_acc_o}, {29'b0, m[1:0], 1'b0});
      end
    end
  endtask

  initial begin
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_reset;
    t_full_view;
    t_sub_views;
    t_accrue;
    t_priority;
    t_rm_resolve;
    t_rm_invalid;
    t_acc_odd;
    t_support;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule